// File: doc/BRIEF.md
# NAND Read-Retry Parameter Sequencer

This block switches a raw NAND flash device into one of several read-retry modes by writing a set of vendor-private threshold registers over the command/address/data bus. A single start pulse with a mode index begins a fixed sequence. The block sends a command that opens parameter-set mode. For each register it then sends the register offset as two identical column address cycles followed by one data byte taken from an external value table. After the last register it sends an apply command. It waits for the device to report ready, reads the status byte and reports success or failure.

The value table sits outside the block and is read through a combinational port. Values for mode m occupy consecutive entries starting at m × NUM_REGS, one per register in register order. Each bus cycle is a single-clock strobe. A mode index outside the configured range is refused at once, and no bus cycle is issued.

The controller is one state machine. Its states are S_IDLE, S_ENTER (entry command), S_ADDR_LO and S_ADDR_HI (the two column cycles), S_DATA (register value), S_APPLY (apply command), S_WAIT_RDY (wait for ready), S_STAT_CMD (status command), S_STAT_RD (status read strobe), S_REPORT (result pulse) and S_REJECT (bad mode). The transitions are as follows:
- S_IDLE goes to S_ENTER on an accepted start, or to S_REJECT on a bad mode.
- S_ENTER goes to S_ADDR_LO, then S_ADDR_HI, then S_DATA.
- S_DATA loops back to S_ADDR_LO for the next register, or goes to S_APPLY after the last one.
- S_APPLY goes to S_WAIT_RDY, which holds until ready is high and then goes to S_STAT_CMD.
- S_STAT_CMD goes to S_STAT_RD, then to S_REPORT.
- S_REPORT and S_REJECT both return to S_IDLE.

Top module: `nand_rr_seq`

## Requirements
- R1: The first bus cycle of an accepted sequence is a command cycle (CLE and WE high, ALE low) carrying 0x36, and an address cycle follows it directly.
- R2: Each register takes exactly three write cycles: two address cycles (ALE and WE high, CLE low) carrying the same 8-bit offset, then one data cycle (WE high, CLE and ALE low).
- R3: Registers are written in offset order 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF (NUM_REGS = 8 by default).
- R4: The data byte for register r in mode m is the table entry at address m × NUM_REGS + r, as presented on tbl_data_i while tbl_addr_o holds that address.
- R5: After the data cycle of the last register, the next write cycle is a command cycle carrying 0x16.
- R6: After the apply command, the block waits until nand_rb_i is high. It then issues command 0x70, followed by exactly one RE strobe.
- R7: If bit 0 of the status byte read during the RE strobe is 1, err_o pulses for one cycle; otherwise done_o pulses for one cycle. The two pulses are never high together.
- R8: A start with mode_i ≥ NUM_MODES makes err_o pulse in the next cycle with no WE, CLE, ALE or RE strobe.
- R9: busy_o is high from the cycle after an accepted start through the cycle of done_o or err_o and low afterwards. A start pulse while busy_o is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| mode_i | input | MODE_W | Requested read-retry mode |
| tbl_addr_o | output | TBL_AW | Value table read address |
| tbl_data_i | input | 8 | Value table read data (combinational) |
| nand_cle_o | output | 1 | Command latch enable strobe |
| nand_ale_o | output | 1 | Address latch enable strobe |
| nand_we_o | output | 1 | Write strobe |
| nand_re_o | output | 1 | Read strobe for the status byte |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_i | input | 8 | Data bus in (status byte) |
| nand_rb_i | input | 1 | Ready (1) / busy (0) from the device |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure or rejection pulse |

## Verification
The bench runs sequences for mode 0, for the last legal mode and for a middle mode. A fixed offset list combined with mode-dependent table contents shows whether the indexing uses the right base and stride. One run holds the device busy for several cycles after apply, and another leaves it ready at once, which separates a wait on ready from a fixed delay. Passing and failing status bytes are applied so that done and error are told apart. Two out-of-range modes and a start pulse in the middle of a sequence check that refused or stray requests put nothing on the bus.

// File: rtl/nand_rr_pkg.sv
package nand_rr_pkg;

    localparam logic [7:0] CMD_ENTER  = 8'h36;
    localparam logic [7:0] CMD_APPLY  = 8'h16;
    localparam logic [7:0] CMD_STATUS = 8'h70;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ENTER,
        S_ADDR_LO,
        S_ADDR_HI,
        S_DATA,
        S_APPLY,
        S_WAIT_RDY,
        S_STAT_CMD,
        S_STAT_RD,
        S_REPORT,
        S_REJECT
    } rr_state_e;

    // Vendor threshold register offsets, in write order.
    function automatic logic [7:0] rr_offset(input int idx);
        case (idx)
            0:       return 8'hCC;
            1:       return 8'hBF;
            2:       return 8'hAA;
            3:       return 8'hAB;
            4:       return 8'hCD;
            5:       return 8'hAD;
            6:       return 8'hAE;
            default: return 8'hAF;
        endcase
    endfunction

endpackage

// File: rtl/nand_rr_offset.sv
module nand_rr_offset #(
    parameter int REG_W = 3
) (
    input  logic [REG_W-1:0] reg_idx_i,
    output logic [7:0]       offset_o
);
    import nand_rr_pkg::*;

    always_comb begin
        offset_o = rr_offset(int'(reg_idx_i));
    end

endmodule

// File: rtl/nand_rr_index.sv
module nand_rr_index #(
    parameter int NUM_REGS = 8,
    parameter int MODE_W   = 3,
    parameter int REG_W    = 3,
    parameter int TBL_AW   = 6
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [REG_W-1:0]  reg_idx_i,
    output logic [TBL_AW-1:0] addr_o,
    output logic              last_o
);
    localparam logic [TBL_AW-1:0] STRIDE   = TBL_AW'(NUM_REGS);
    localparam logic [REG_W-1:0]  LAST_IDX = REG_W'(NUM_REGS - 1);

    always_comb begin
        addr_o = TBL_AW'(mode_i) * STRIDE + TBL_AW'(reg_idx_i);
        last_o = (reg_idx_i == LAST_IDX);
    end

endmodule

// File: rtl/nand_rr_seq.sv
module nand_rr_seq #(
    parameter int NUM_MODES = 6,
    parameter int NUM_REGS  = 8,
    parameter int MODE_W    = 3,
    parameter int TBL_AW    = $clog2(NUM_MODES * NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [TBL_AW-1:0] tbl_addr_o,
    input  logic [7:0]        tbl_data_i,
    output logic              nand_cle_o,
    output logic              nand_ale_o,
    output logic              nand_we_o,
    output logic              nand_re_o,
    output logic [7:0]        nand_dq_o,
    input  logic [7:0]        nand_dq_i,
    input  logic              nand_rb_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    import nand_rr_pkg::*;

    localparam int REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    rr_state_e         state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic [REG_W-1:0]  reg_q;
    logic              fail_q;
    logic [7:0]        offset;
    logic              last_reg;
    logic              mode_bad;
    logic              dq_in_unused;

    assign mode_bad     = (32'(mode_i) >= NUM_MODES);
    assign dq_in_unused = ^nand_dq_i[7:1];

    nand_rr_offset #(.REG_W(REG_W)) u_offset (
        .reg_idx_i (reg_q),
        .offset_o  (offset)
    );

    nand_rr_index #(
        .NUM_REGS (NUM_REGS),
        .MODE_W   (MODE_W),
        .REG_W    (REG_W),
        .TBL_AW   (TBL_AW)
    ) u_index (
        .mode_i    (mode_q),
        .reg_idx_i (reg_q),
        .addr_o    (tbl_addr_o),
        .last_o    (last_reg)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_i) state_d = mode_bad ? S_REJECT : S_ENTER;
            S_ENTER:    state_d = S_ADDR_LO;
            S_ADDR_LO:  state_d = S_ADDR_HI;
            S_ADDR_HI:  state_d = S_DATA;
            S_DATA:     state_d = last_reg ? S_APPLY : S_ADDR_LO;
            S_APPLY:    state_d = S_WAIT_RDY;
            S_WAIT_RDY: if (nand_rb_i) state_d = S_STAT_CMD;
            S_STAT_CMD: state_d = S_STAT_RD;
            S_STAT_RD:  state_d = S_REPORT;
            S_REPORT:   state_d = S_IDLE;
            S_REJECT:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Sequence datapath: mode latch, register counter, status capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            reg_q  <= '0;
            fail_q <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start_i && !mode_bad) begin
                mode_q <= mode_i;
                reg_q  <= '0;
            end
            if (state_q == S_DATA && !last_reg) reg_q <= reg_q + 1'b1;
            if (state_q == S_STAT_RD) fail_q <= nand_dq_i[0];
        end
    end

    // Outputs
    always_comb begin
        nand_cle_o = 1'b0;
        nand_ale_o = 1'b0;
        nand_we_o  = 1'b0;
        nand_re_o  = 1'b0;
        nand_dq_o  = 8'h00;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        err_o      = 1'b0;
        unique case (state_q)
            S_IDLE:     busy_o = 1'b0;
            S_ENTER:    begin nand_cle_o = 1'b1; nand_we_o = 1'b1; nand_dq_o = CMD_ENTER; end
            S_ADDR_LO,
            S_ADDR_HI:  begin nand_ale_o = 1'b1; nand_we_o = 1'b1; nand_dq_o = offset; end
            S_DATA:     begin nand_we_o = 1'b1; nand_dq_o = tbl_data_i; end
            S_APPLY:    begin nand_cle_o = 1'b1; nand_we_o = 1'b1; nand_dq_o = CMD_APPLY; end
            S_WAIT_RDY: ;
            S_STAT_CMD: begin nand_cle_o = 1'b1; nand_we_o = 1'b1; nand_dq_o = CMD_STATUS; end
            S_STAT_RD:  nand_re_o = 1'b1;
            S_REPORT:   begin done_o = !fail_q; err_o = fail_q; end
            S_REJECT:   err_o = 1'b1;
            default:    busy_o = 1'b0;
        endcase
    end

    // Assertions
    assert_enter_then_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle_o && nand_we_o && nand_dq_o == 8'h36) |=> (nand_ale_o && nand_we_o));

    assert_addr_pair_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_ale_o && $past(nand_ale_o)) |-> (nand_dq_o == $past(nand_dq_o)));

    assert_read_after_status_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nand_re_o |-> $past(nand_cle_o && nand_dq_o == 8'h70));

    assert_result_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && 32'(mode_i) >= NUM_MODES) |=> (err_o && !nand_we_o && !nand_re_o));

    assert_busy_ends_on_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o || err_o));

endmodule

// File: tb/tb_nand_rr_seq.sv
module tb_nand_rr_seq;
    localparam int NM = 6;
    localparam int NR = 8;
    localparam int MW = 3;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [MW-1:0] mode = '0;
    logic [AW-1:0] tbl_addr;
    logic [7:0]    tbl_data;
    logic          cle, ale, we, re;
    logic [7:0]    dq_o;
    logic [7:0]    stat_val = 8'h00;
    logic          rb = 1'b1;
    logic          busy, done, err;

    int checks = 0;
    int failures = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    int rdy_delay = 0;
    int rdy_cnt = 0;
    int cycles = 0;
    logic [9:0] exp_q[$];

    localparam logic [7:0] OFFS [8] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};

    function automatic logic [7:0] tbl_val(input int a);
        return 8'((a * 29 + 7) ^ 8'h5A);
    endfunction

    assign tbl_data = tbl_val(int'(tbl_addr));

    always #10 clk = ~clk;

    nand_rr_seq #(.NUM_MODES(NM), .NUM_REGS(NR), .MODE_W(MW), .TBL_AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_data),
        .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_o(we), .nand_re_o(re),
        .nand_dq_o(dq_o), .nand_dq_i(stat_val), .nand_rb_i(rb),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each write strobe against the scoreboard, model ready/busy
    always @(negedge clk) begin
        cycles++;
        if (rst_n && we) begin
            we_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected write cycle", {cle, ale, dq_o}, 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                check({cle, ale, dq_o} == e, "R1/R2/R3/R4/R5 bus cycle", {cle, ale, dq_o}, e);
            end
            if (cle && dq_o == 8'h16 && rdy_delay > 0) begin
                rb <= 1'b0;
                rdy_cnt = rdy_delay;
            end
        end else if (rdy_cnt > 0) begin
            rdy_cnt--;
            if (rdy_cnt == 0) rb <= 1'b1;
        end
        if (rst_n && re) begin
            re_cnt++;
            check(rb == 1'b1, "R6 read strobe while busy", rb, 1);
        end
    end

    task automatic run_mode(input int m, input logic [7:0] stat, input int slow, input bit intrude);
        int re0;
        int n;
        exp_q.push_back({2'b10, 8'h36});
        for (int r = 0; r < NR; r++) begin
            exp_q.push_back({2'b01, OFFS[r]});
            exp_q.push_back({2'b01, OFFS[r]});
            exp_q.push_back({2'b00, tbl_val(m * NR + r)});
        end
        exp_q.push_back({2'b10, 8'h16});
        exp_q.push_back({2'b10, 8'h70});
        stat_val  = stat;
        rdy_delay = slow;
        re0 = re_cnt;
        @(negedge clk);
        start = 1'b1;
        mode  = MW'(m);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        if (intrude) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            mode  = MW'((m + 1) % NM);
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!(done || err) && n < 200) begin
            check(busy == 1'b1, "R9 busy during sequence", busy, 1);
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, "R5 all write cycles issued", exp_q.size(), 0);
        check(re_cnt - re0 == 1, "R6 one status read", re_cnt - re0, 1);
        check(err == stat[0], "R7 error pulse", err, stat[0]);
        check(done == !stat[0], "R7 done pulse", done, !stat[0]);
        check(busy == 1'b1, "R9 busy on result cycle", busy, 1);
        @(negedge clk);
        check(!busy && !done && !err, "R9 idle after result", {busy, done, err}, 0);
        exp_q.delete();
    endtask

    task automatic reject(input int m);
        int w0, r0;
        w0 = we_cnt;
        r0 = re_cnt;
        @(negedge clk);
        start = 1'b1;
        mode  = MW'(m);
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b1 && done == 1'b0, "R8 reject pulse", {done, err}, 1);
        @(negedge clk);
        check(!err && !busy, "R8 reject one cycle", {busy, err}, 0);
        repeat (3) @(negedge clk);
        check(we_cnt == w0 && re_cnt == r0, "R8 no bus activity", we_cnt - w0 + re_cnt - r0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && !we && !cle && !ale && !re, "R9 reset state",
              {busy, done, err, we, cle, ale, re}, 0);
        run_mode(0, 8'h00, 0, 1'b0);
        run_mode(NM - 1, 8'hE0, 5, 1'b0);
        run_mode(3, 8'h01, 2, 1'b0);
        run_mode(2, 8'hC0, 7, 1'b1);
        reject(NM);
        reject(7);
        run_mode(1, 8'h41, 0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule